// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block connects a CPU-side bus that issues big-endian accesses of one, two or four bytes to a register file whose registers do not all share one width. Every 4-byte group of the register window has a native width, taken from a fixed width table that the block computes. A bus access of the native width passes straight through. An access wider than the native width is cut into several register accesses at ascending addresses. An access narrower than the native width goes to the aligned register that contains it: a read extracts the addressed byte lanes, and a write becomes a read-modify-write that keeps the other lanes.

The register side is a simple port. The adapter presents a valid strobe, an address, a size code, a write flag and write data. The register file answers a read combinationally in the same cycle and takes a write on the clock edge. The adapter issues one register access per cycle. It holds the bus side not-ready from the moment it accepts a request until the final result has been reported, so a multi-step sequence is never interleaved with another request. Requests that fall outside the window, hit an unimplemented group, are misaligned or use the reserved size code finish with an error flag and touch no register.

Top module: `mxw_access_adapter`

## Requirements
- R1: Only the low 10 bits of `bus_addr` form the offset, so addresses that differ only above bit 9 reach the same register.
- R2: A request ends with `bus_err`=1, `bus_rdata`=0 and no register access if any of these holds: the offset is above 0x200, the size code is 3, a 2-byte access has offset bit 0 set, a 4-byte access has offset bits 1:0 nonzero, or the offset's group is unimplemented.
- R3: Size codes are 0 = one byte, 1 = two bytes, 2 = four bytes. The native width of group g = offset[9:2] is: byte for 0x000–0x02F; two bytes for 0x030–0x03F; for 0x040–0x0BF four bytes when ((offset-0x40)/4) mod 3 = 0 and two bytes otherwise; unimplemented for 0x0C0–0x0FF; two bytes for 0x100–0x13F; byte for 0x140–0x1FF; unimplemented from 0x200.
- R4: An access whose size equals the native width makes exactly one register access at the bus offset.
- R5: A narrow read (size below the native width) makes one register read at the offset rounded down to the native width. It returns the addressed bytes, where a lower address sits in a more significant lane.
- R6: A wide access (size above the native width) makes size/width register accesses at offset, offset+width and so on. The first of these carries the most significant part of the bus data.
- R7: A narrow write makes a read and then a write of the same aligned register. Only the addressed lanes change, and the other bytes keep their values.
- R8: `bus_ready` is 1 after reset and in idle. It stays 0 from the edge that accepts a request until `bus_done` has pulsed for one cycle. `bus_done` rises in the cycle after the last register access.
- R9: Every register access uses the native width of its group as `reg_size` and is aligned to that width.
- R10: Bus and register data sit right-aligned in the low bytes. A completed write reports `bus_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Request, taken when `bus_ready` is high |
| bus_ready | output | 1 | Adapter idle and able to accept |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address, masked to the offset width |
| bus_size | input | 2 | 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Bad access, valid with `bus_done` |
| bus_rdata | output | 32 | Read result, valid with `bus_done` |
| reg_valid | output | 1 | Register access this cycle |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | ADDR_W | Register byte offset |
| reg_size | output | 2 | Native width code of the access |
| reg_wdata | output | 32 | Register write data, right-aligned |
| reg_rdata | input | 32 | Register read data, right-aligned, same cycle |

## Verification
Lane merging and read-back fall in the same cycle. In the first step of a narrow write, the register's current value is read and merged with the bus bytes, and the result must be stored for the write in the next cycle. Every aligned and misaligned offset up to 0x20F is written at each size and then read back at once. A final byte-by-byte sweep of the whole window is compared against a byte-level model in the bench, so any lane that a merge clobbered shows up in a neighbouring location. The number of register accesses per request and the width of each one are judged against the width table, which the bench evaluates on its own.

// File: rtl/mxw_pkg.sv
package mxw_pkg;

   localparam int DW = 32;

   typedef logic [1:0] szc_t;
   localparam szc_t SZC_B = 2'd0;
   localparam szc_t SZC_H = 2'd1;
   localparam szc_t SZC_W = 2'd2;
   localparam szc_t SZC_X = 2'd3;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

   // native width per 4-byte group index
   function automatic szc_t grp_width(input int unsigned g);
      if (g < 12)       return SZC_B;
      else if (g < 16)  return SZC_H;
      else if (g < 48)  return ((g - 16) % 3 == 0) ? SZC_W : SZC_H;
      else if (g < 64)  return SZC_X;
      else if (g < 80)  return SZC_H;
      else if (g < 128) return SZC_B;
      return SZC_X;
   endfunction

   function automatic logic [DW-1:0] lane_mask(input szc_t s);
      case (s)
         SZC_B:   return 32'h0000_00FF;
         SZC_H:   return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/mxw_decode.sv
module mxw_decode
   import mxw_pkg::*;
#(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned TOP_OFS = 'h200
) (
   input  logic [ADDR_W-1:0] off,
   input  szc_t              size,
   input  logic              we,
   output logic              bad,
   output szc_t              unit,
   output logic [ADDR_W-1:0] base,
   output logic [1:0]        lane,
   output logic [2:0]        nsteps,
   output logic              narrow
);
   logic misal;

   always_comb begin
      unit   = grp_width(32'(off) >> 2);
      misal  = (size == SZC_H && off[0]) || (size == SZC_W && off[1:0] != 2'b00);
      bad    = (size == SZC_X) || misal || (32'(off) > TOP_OFS) || (unit == SZC_X);
      narrow = size < unit;
      case (unit)
         SZC_W:   lane = off[1:0];
         SZC_H:   lane = {1'b0, off[0]};
         default: lane = 2'b00;
      endcase
      base = off - ADDR_W'(lane);
      if (narrow)
         nsteps = we ? 3'd2 : 3'd1;
      else if (size > unit)
         nsteps = 3'd1 << (size - unit);
      else
         nsteps = 3'd1;
   end
endmodule

// File: rtl/mxw_lane.sv
module mxw_lane
   import mxw_pkg::*;
(
   input  szc_t          unit,
   input  szc_t          size,
   input  logic [1:0]    lane,
   input  logic [2:0]    step,
   input  logic [2:0]    nsteps,
   input  logic          narrow,
   input  logic          we,
   input  logic [DW-1:0] acc,
   input  logic [DW-1:0] rdata,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] acc_next,
   output logic [DW-1:0] split_wdata
);
   logic [DW-1:0] rd_u;
   logic [DW-1:0] sm;
   int            sh;
   int            ubits;
   int            wsh;

   always_comb begin
      rd_u  = rdata & lane_mask(unit);
      sm    = lane_mask(size);
      ubits = 8 << unit;
      // big-endian: lowest address in the most significant lane
      sh    = 8 * ((1 << unit) - int'(lane) - (1 << size));
      wsh   = ubits * int'(nsteps - step - 3'd1);
      if (narrow) begin
         if (we) acc_next = (rd_u & ~(sm << sh)) | ((wdata & sm) << sh);
         else    acc_next = (rd_u >> sh) & sm;
      end else if (unit == SZC_W) begin
         acc_next = rd_u;
      end else begin
         acc_next = (acc << ubits) | rd_u;
      end
      split_wdata = (wdata >> wsh) & lane_mask(unit);
   end
endmodule

// File: rtl/mxw_access_adapter.sv
module mxw_access_adapter
   import mxw_pkg::*;
#(
   parameter int unsigned BUS_AW  = 12,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned TOP_OFS = 'h200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   output logic              bus_ready,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DW-1:0]     bus_wdata,
   output logic              bus_done,
   output logic              bus_err,
   output logic [DW-1:0]     bus_rdata,
   output logic              reg_valid,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [1:0]        reg_size,
   output logic [DW-1:0]     reg_wdata,
   input  logic [DW-1:0]     reg_rdata
);
   if (ADDR_W < 10) begin : g_chk_aw
      $error("ADDR_W must cover the 10-bit offset");
   end
   if (BUS_AW < ADDR_W) begin : g_chk_bus
      $error("BUS_AW must not be narrower than ADDR_W");
   end
   if (TOP_OFS >= (1 << ADDR_W)) begin : g_chk_top
      $error("TOP_OFS must lie inside the offset space");
   end

   logic [ADDR_W-1:0] off;
   if (BUS_AW > ADDR_W) begin : g_trim
      logic unused_hi;
      assign unused_hi = ^bus_addr[BUS_AW-1:ADDR_W];
      assign off = bus_addr[ADDR_W-1:0];
   end else begin : g_same
      assign off = bus_addr;
   end

   logic              d_bad, d_narrow;
   szc_t              d_unit;
   logic [ADDR_W-1:0] d_base;
   logic [1:0]        d_lane;
   logic [2:0]        d_n;

   mxw_decode #(.ADDR_W(ADDR_W), .TOP_OFS(TOP_OFS)) u_dec (
      .off(off), .size(bus_size), .we(bus_we), .bad(d_bad), .unit(d_unit),
      .base(d_base), .lane(d_lane), .nsteps(d_n), .narrow(d_narrow)
   );

   st_e               st;
   logic [2:0]        step, q_n;
   logic              q_we, q_narrow, q_bad;
   szc_t              q_size, q_unit;
   logic [ADDR_W-1:0] q_base;
   logic [1:0]        q_lane;
   logic [DW-1:0]     q_wdata, acc;
   logic [DW-1:0]     l_acc, l_wdata;

   mxw_lane u_lane (
      .unit(q_unit), .size(q_size), .lane(q_lane), .step(step), .nsteps(q_n),
      .narrow(q_narrow), .we(q_we), .acc(acc), .rdata(reg_rdata),
      .wdata(q_wdata), .acc_next(l_acc), .split_wdata(l_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         step     <= '0;
         q_n      <= '0;
         q_we     <= 1'b0;
         q_narrow <= 1'b0;
         q_bad    <= 1'b0;
         q_size   <= SZC_B;
         q_unit   <= SZC_B;
         q_base   <= '0;
         q_lane   <= '0;
         q_wdata  <= '0;
         acc      <= '0;
      end else begin
         case (st)
            ST_IDLE: if (bus_req) begin
               q_we     <= bus_we;
               q_size   <= bus_size;
               q_unit   <= d_unit;
               q_base   <= d_base;
               q_lane   <= d_lane;
               q_n      <= d_n;
               q_narrow <= d_narrow;
               q_bad    <= d_bad;
               q_wdata  <= bus_wdata;
               acc      <= '0;
               step     <= '0;
               st       <= d_bad ? ST_FIN : ST_RUN;
            end
            ST_RUN: begin
               // the write step of a merge keeps the merged word
               if (!(q_narrow && step != 3'd0)) acc <= l_acc;
               step <= step + 3'd1;
               if (step == q_n - 3'd1) st <= ST_FIN;
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign bus_ready = (st == ST_IDLE);
   assign bus_done  = (st == ST_FIN);
   assign bus_err   = bus_done && q_bad;
   assign bus_rdata = (bus_done && !q_we && !q_bad) ? acc : '0;

   assign reg_valid = (st == ST_RUN);
   assign reg_we    = reg_valid && q_we && (!q_narrow || step == 3'd1);
   assign reg_size  = q_unit;
   assign reg_addr  = q_narrow ? q_base : q_base + (ADDR_W'(step) << q_unit);
   assign reg_wdata = q_narrow ? acc : l_wdata;
endmodule

// File: rtl/mxw_access_adapter_chk.sv
module mxw_access_adapter_chk #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned TOP_OFS = 'h200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_ready,
   input logic              bus_we,
   input logic              bus_done,
   input logic              bus_err,
   input logic [31:0]       bus_rdata,
   input logic              reg_valid,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [1:0]        reg_size
);
   logic last_we;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_we <= 1'b0;
      else if (bus_req && bus_ready) last_we <= bus_we;
   end

   a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |-> !bus_ready);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_done |=> (bus_ready && !bus_done));

   a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |-> (reg_size != 2'd3) &&
                    !(reg_size == 2'd1 && reg_addr[0]) &&
                    !(reg_size == 2'd2 && reg_addr[1:0] != 2'b00));

   a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |-> (32'(reg_addr) <= TOP_OFS));

   a_r2_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done && bus_err) |-> (!$past(reg_valid) && bus_rdata == 32'd0));

   a_r7_rmw_same: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_we && $past(reg_valid) && !$past(reg_we)) |->
         (reg_addr == $past(reg_addr) && reg_size == $past(reg_size)));

   a_r10_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done && last_we) |-> (bus_rdata == 32'd0));
endmodule

bind mxw_access_adapter mxw_access_adapter_chk #(.ADDR_W(ADDR_W), .TOP_OFS(TOP_OFS)) u_chk (.*);

// File: tb/mxw_access_adapter_test.sv
`timescale 1ns/1ps
module mxw_access_adapter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready, bus_done, bus_err;
   logic [31:0] bus_rdata;
   logic        reg_valid, reg_we;
   logic [9:0]  reg_addr;
   logic [1:0]  reg_size;
   logic [31:0] reg_wdata, reg_rdata;

   int vectors = 0;
   int miscompares = 0;
   int acc_cnt = 0;

   logic [7:0] rf [0:1023];
   logic [7:0] shadow [0:1023];

   always #2 clk = ~clk;

   mxw_access_adapter uut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ready(bus_ready),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_err(bus_err),
      .bus_rdata(bus_rdata), .reg_valid(reg_valid), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   // register file model: big-endian, combinational read
   always_comb begin
      case (reg_size)
         2'd0:    reg_rdata = {24'd0, rf[reg_addr]};
         2'd1:    reg_rdata = {16'd0, rf[reg_addr], rf[reg_addr + 10'd1]};
         default: reg_rdata = {rf[reg_addr], rf[reg_addr + 10'd1],
                               rf[reg_addr + 10'd2], rf[reg_addr + 10'd3]};
      endcase
   end

   always @(posedge clk) begin
      if (reg_valid && reg_we) begin
         case (reg_size)
            2'd0: rf[reg_addr] <= reg_wdata[7:0];
            2'd1: begin
               rf[reg_addr]         <= reg_wdata[15:8];
               rf[reg_addr + 10'd1] <= reg_wdata[7:0];
            end
            default: begin
               rf[reg_addr]         <= reg_wdata[31:24];
               rf[reg_addr + 10'd1] <= reg_wdata[23:16];
               rf[reg_addr + 10'd2] <= reg_wdata[15:8];
               rf[reg_addr + 10'd3] <= reg_wdata[7:0];
            end
         endcase
      end
   end

   // width table written from the requirement text (R3)
   function automatic logic [1:0] tb_width(input int o);
      if (o < 'h30)  return 2'd0;
      if (o < 'h40)  return 2'd1;
      if (o < 'hC0)  return (((o - 'h40) / 4) % 3 == 0) ? 2'd2 : 2'd1;
      if (o < 'h100) return 2'd3;
      if (o < 'h140) return 2'd1;
      if (o < 'h200) return 2'd0;
      return 2'd3;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor for R9 / R3: register access width and alignment
   always @(negedge clk) begin
      if (rst_n && reg_valid) begin
         acc_cnt++;
         if (reg_size != tb_width(int'(reg_addr)) ||
             (reg_size == 2'd1 && reg_addr[0]) ||
             (reg_size == 2'd2 && reg_addr[1:0] != 2'b00)) begin
            miscompares++;
            $display("FAIL R9 actual=%h expected=%h", {reg_size, reg_addr},
                     {tb_width(int'(reg_addr)), reg_addr});
         end
      end
   end

   task automatic do_acc(input logic [11:0] a, input logic [1:0] sz, input bit we,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output bit err, output int nacc, output bit stall_ok);
      int n;
      @(negedge clk);
      n = 0;
      while (!bus_ready && n < 40) begin @(negedge clk); n++; end
      acc_cnt   = 0;
      bus_req   = 1'b1;
      bus_we    = we;
      bus_addr  = a;
      bus_size  = sz;
      bus_wdata = wd;
      @(negedge clk);
      bus_req  = 1'b0;
      stall_ok = 1'b1;
      n = 0;
      while (!bus_done && n < 40) begin
         if (bus_ready) stall_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      if (!bus_done || bus_ready) stall_ok = 1'b0;
      rd   = bus_rdata;
      err  = bus_err;
      nacc = acc_cnt;
      @(negedge clk);
      if (!bus_ready || bus_done) stall_ok = 1'b0;
   endtask

   task automatic run_case(input logic [11:0] a, input int sz, input bit we,
                           input logic [31:0] wd);
      int          o, sb, wb, nexp;
      logic [1:0]  w;
      bit          bad, err, st_ok;
      logic [31:0] rd, exp;
      int          nacc;
      string       tag;
      o   = int'(a[9:0]);
      w   = tb_width(o);
      sb  = 1 << sz;
      bad = (sz == 3) || (sz == 1 && o[0]) || (sz == 2 && o[1:0] != 2'b00) ||
            (o > 'h200) || (w == 2'd3);
      wb  = 1 << w;
      do_acc(a, 2'(sz), we, wd, rd, err, nacc, st_ok);
      check(st_ok, "R8 stall/done", {31'd0, st_ok}, 32'd1);
      check(err == bad, "R2 error flag", {31'd0, err}, {31'd0, bad});
      if (bad) begin
         check(nacc == 0 && rd == 32'd0, "R2 no access", 32'(nacc), 32'd0);
         return;
      end
      if (sb == wb)     begin tag = "R4"; nexp = 1; end
      else if (sb > wb) begin tag = "R6"; nexp = sb / wb; end
      else if (we)      begin tag = "R7"; nexp = 2; end
      else              begin tag = "R5"; nexp = 1; end
      check(nacc == nexp, {tag, " access count"}, 32'(nacc), 32'(nexp));
      if (we) begin
         check(rd == 32'd0, "R10 write rdata", rd, 32'd0);
         for (int i = 0; i < sb; i++)
            shadow[o + i] = 8'(wd >> (8 * (sb - 1 - i)));
      end else begin
         exp = '0;
         for (int i = 0; i < sb; i++) exp = (exp << 8) | 32'(shadow[o + i]);
         check(rd == exp, {tag, " R10 read data"}, rd, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] wd;
      for (int i = 0; i < 1024; i++) begin
         rf[i]     = 8'(i * 37 + 11);
         shadow[i] = 8'(i * 37 + 11);
      end
      repeat (3) @(negedge clk);
      check(bus_ready && !bus_done && !reg_valid, "R8 reset state",
            {29'd0, bus_ready, bus_done, reg_valid}, 32'h4);
      rst_n = 1'b1;

      // every offset, every size, write then immediate read-back
      for (int sz = 0; sz < 3; sz++) begin
         for (int o = 0; o < 'h210; o++) begin
            wd = 32'h9E37_79B9 * 32'(o * 3 + sz + 1);
            run_case(12'(o), sz, 1'b1, wd);
            run_case(12'(o), sz, 1'b0, 32'd0);
         end
      end

      // reserved size code (R2)
      run_case(12'h010, 3, 1'b1, 32'h1234_5678);
      run_case(12'h104, 3, 1'b0, 32'd0);

      // upper address bits ignored (R1)
      run_case(12'hD06, 1, 1'b1, 32'h0000_BEEF);
      run_case(12'h106, 1, 1'b0, 32'd0);
      run_case(12'h940, 2, 1'b1, 32'hCAFE_F00D);
      run_case(12'h541, 0, 1'b0, 32'd0);
      run_case(12'h040, 2, 1'b0, 32'd0);

      // whole-window byte sweep to catch lanes clobbered by merges (R7)
      for (int o = 0; o < 1024; o++) run_case(12'(o), 0, 1'b0, 32'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule